// File: doc/BRIEF.md
# Queued Serial Transmitter with Send-Gating

This block turns parallel characters into an asynchronous serial stream on one line. Characters enter a small first-in-first-out queue through a single-cycle write strobe. A frame engine takes them out one at a time. For each character it sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from a 16-bit divisor that produces a tick sixteen times per bit.

Several controls shape the frame. Format inputs select 8 or 9 data bits, even, odd or no parity, and one or two stop bits. The format is captured when each frame starts. With flow control enabled, an active-low clear-to-send input holds back the start of each new character. A break request sends a long low period ahead of any queued data. A loopback switch routes the serial stream to an internal receive-side output and keeps the external pin idle high. The interrupt output stays high while the queue can accept a character.

Top module: `sertx_top`

## Requirements
- R1: The queue holds exactly 4 characters, and a write to a full queue is dropped. `tx_irq` is high whenever at least one entry is free and low when all 4 are used.
- R2: A frame is a low start bit followed by the data bits, least significant first, and then a high stop bit. The line idles high.
- R3: When `data9` is 1, nine data bits are sent and bit 8 follows bit 7. No parity bit is inserted, whatever `par_mode` says.
- R4: With 8 data bits, `par_mode` 2'b01 adds one even-parity bit after bit 7, and 2'b10 adds one odd-parity bit there. The values 2'b00 and 2'b11 add no parity bit.
- R5: `two_stop` = 0 ends the frame with one high stop bit, and `two_stop` = 1 ends it with two.
- R6: While `flow_en` is 1 and `cts_n` is 1, no new frame starts. A queued character starts once `cts_n` goes low.
- R7: Every bit lasts 16*(`divisor`+1) clock cycles.
- R8: A pulse on `break_req` makes the line go low for 13 bit periods, followed by one stop bit. A pending break is sent before any queued character.
- R9: With `loopback` = 1, `txd` stays high and `loop_rx` carries the serial stream. With `loopback` = 0, `loop_rx` stays high.
- R10: After reset, `txd` and `loop_rx` are high, `tx_irq` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 9 | Character to queue (bit 8 used in 9-bit mode) |
| data9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_mode | input | 2 | 01 even, 10 odd, 00/11 none |
| two_stop | input | 1 | 1 selects two stop bits |
| flow_en | input | 1 | Enables gating by clear-to-send |
| cts_n | input | 1 | Active-low clear-to-send |
| break_req | input | 1 | Pulse that requests a break |
| loopback | input | 1 | Routes the stream internally and idles the pin |
| divisor | input | 16 | Tick divisor; tick every divisor+1 clocks |
| txd | output | 1 | Serial output pin |
| loop_rx | output | 1 | Internal receive-side feed |
| tx_irq | output | 1 | Queue has a free entry |
| busy | output | 1 | A frame or break is in progress |

## Verification
The assertions check on every cycle that the queue never holds more than four entries and that a write into a full queue leaves the fill level unchanged. They also check that the frame state only advances at a bit boundary, that a frame never starts while send-gating holds it back, that parity never appears in 9-bit frames, that a break drives the line low, and that loopback idles the pin. Only the bench scenarios can show the bit order on the wire, the correct parity value, the stop-bit lengths, the exact bit duration for a given divisor, and break ordering ahead of queued data. The same holds for the order in which queued characters leave.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int BREAK_BITS    = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } tx_state_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(logic nine, logic [1:0] pm, logic two);
        frame_cfg_t c;
        c.nine     = nine;
        c.par_en   = !nine && (pm == 2'b01 || pm == 2'b10);
        c.par_odd  = (pm == 2'b10);
        c.two_stop = two;
        return c;
    endfunction

    function automatic logic parity_of(logic [7:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_q;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count_q == '0);
    assign full    = (count_q == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assert_fifo_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

    assert_full_write_dropped_R1: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (count_q == CW'(DEPTH)));

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_done
);
    import sertx_pkg::*;
    localparam int SW = $clog2(TICKS_PER_BIT);

    logic [DIV_W-1:0] cnt_q;
    logic [SW-1:0]    sub_q;
    logic             tick;

    assign tick     = run && (cnt_q == divisor);
    assign bit_done = tick && (sub_q == SW'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            sub_q <= '0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (tick) sub_q <= sub_q + 1'b1;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_empty,
    input  logic [8:0] fifo_data,
    output logic       fifo_pop,
    input  logic       data9,
    input  logic [1:0] par_mode,
    input  logic       two_stop,
    input  logic       flow_en,
    input  logic       cts_n,
    input  logic       break_req,
    input  logic       bit_done,
    output logic       run,
    output logic       line_q,
    output logic       busy
);
    import sertx_pkg::*;

    tx_state_e  state_q;
    frame_cfg_t cfg_q;
    logic [8:0] shreg_q;
    logic [3:0] idx_q;
    logic       stop2_q;
    logic       brk_pend_q;
    logic       par_q;
    logic       line_d;
    logic       may_send;
    logic       take_brk;
    logic [3:0] last_idx;

    assign may_send = !flow_en || !cts_n;
    assign take_brk = (state_q == ST_IDLE) && brk_pend_q;
    assign fifo_pop = (state_q == ST_IDLE) && !brk_pend_q && !fifo_empty && may_send;
    assign run      = (state_q != ST_IDLE);
    assign busy     = run;
    assign last_idx = cfg_q.nine ? 4'd8 : 4'd7;

    always_comb begin
        case (state_q)
            ST_START: line_d = 1'b0;
            ST_DATA:  line_d = shreg_q[0];
            ST_PAR:   line_d = par_q;
            ST_BRK:   line_d = 1'b0;
            default:  line_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            shreg_q    <= '0;
            idx_q      <= '0;
            stop2_q    <= 1'b0;
            brk_pend_q <= 1'b0;
            par_q      <= 1'b0;
            line_q     <= 1'b1;
        end else begin
            line_q     <= line_d;
            brk_pend_q <= (brk_pend_q && !take_brk) || break_req;
            case (state_q)
                ST_IDLE: begin
                    if (take_brk) begin
                        state_q <= ST_BRK;
                        idx_q   <= '0;
                    end else if (fifo_pop) begin
                        cfg_q   <= decode_cfg(data9, par_mode, two_stop);
                        shreg_q <= fifo_data;
                        par_q   <= parity_of(fifo_data[7:0], par_mode == 2'b10);
                        idx_q   <= '0;
                        state_q <= ST_START;
                    end
                end
                ST_START: if (bit_done) state_q <= ST_DATA;
                ST_DATA: if (bit_done) begin
                    shreg_q <= {1'b0, shreg_q[8:1]};
                    if (idx_q == last_idx) begin
                        if (cfg_q.par_en) begin
                            state_q <= ST_PAR;
                        end else begin
                            state_q <= ST_STOP;
                            stop2_q <= cfg_q.two_stop;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_PAR: if (bit_done) begin
                    state_q <= ST_STOP;
                    stop2_q <= cfg_q.two_stop;
                end
                ST_STOP: if (bit_done) begin
                    if (stop2_q) stop2_q <= 1'b0;
                    else         state_q <= ST_IDLE;
                end
                ST_BRK: if (bit_done) begin
                    if (idx_q == 4'(BREAK_BITS - 1)) begin
                        state_q <= ST_STOP;
                        stop2_q <= 1'b0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_bit_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && !bit_done) |=> $stable(state_q));

    assert_cts_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && flow_en && cts_n) |=> (state_q != ST_START));

    assert_no_parity_nine_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAR) |-> !cfg_q.nine);

    assert_break_low_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRK) |=> !line_q);

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DEPTH = 4,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [8:0]       wr_data,
    input  logic             data9,
    input  logic [1:0]       par_mode,
    input  logic             two_stop,
    input  logic             flow_en,
    input  logic             cts_n,
    input  logic             break_req,
    input  logic             loopback,
    input  logic [DIV_W-1:0] divisor,
    output logic             txd,
    output logic             loop_rx,
    output logic             tx_irq,
    output logic             busy
);
    logic [8:0] fifo_data;
    logic       fifo_empty, fifo_full, fifo_pop;
    logic       run, bit_done, line;

    sertx_fifo #(.DEPTH(DEPTH), .W(9)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(fifo_pop), .rd_data(fifo_data),
        .empty(fifo_empty), .full(fifo_full)
    );

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(run),
        .divisor(divisor), .bit_done(bit_done)
    );

    sertx_shifter u_shift (
        .clk(clk), .rst(rst),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .data9(data9), .par_mode(par_mode), .two_stop(two_stop),
        .flow_en(flow_en), .cts_n(cts_n), .break_req(break_req),
        .bit_done(bit_done), .run(run), .line_q(line), .busy(busy)
    );

    assign txd     = loopback ? 1'b1 : line;
    assign loop_rx = loopback ? line : 1'b1;
    assign tx_irq  = !fifo_full;

    assert_loop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        loopback |-> txd);

    assert_irq_room_R1: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty) |-> tx_irq);

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       data9 = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       flow_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       break_req = 1'b0;
    logic       loopback = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic       txd, loop_rx, tx_irq, busy;

    int checks = 0;
    int fails  = 0;
    int txd_low_in_loop = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .data9(data9), .par_mode(par_mode), .two_stop(two_stop),
        .flow_en(flow_en), .cts_n(cts_n), .break_req(break_req),
        .loopback(loopback), .divisor(divisor),
        .txd(txd), .loop_rx(loop_rx), .tx_irq(tx_irq), .busy(busy)
    );

    always @(negedge clk) if (loopback && txd !== 1'b1) txd_low_in_loop++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic cur(input bit sel);
        return sel ? loop_rx : txd;
    endfunction

    task automatic push(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic capture(input bit sel, input int n, output logic [15:0] b);
        b = '0;
        while (cur(sel) !== 1'b0) @(negedge clk);
        repeat (16) @(negedge clk);
        b[0] = cur(sel);
        for (int i = 1; i < n; i++) begin
            repeat (32) @(negedge clk);
            b[i] = cur(sel);
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (txd !== lvl) @(negedge clk);
        while (txd === lvl) begin n++; @(negedge clk); end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] expect_frame(input logic [8:0] d, input bit nine,
                                                 input logic [1:0] pm, output int n);
        logic [15:0] b = '0;
        int k = 1;
        int nd = nine ? 9 : 8;
        for (int i = 0; i < nd; i++) begin b[k] = d[i]; k++; end
        if (!nine && (pm == 2'b01 || pm == 2'b10)) begin
            b[k] = (^d[7:0]) ^ (pm == 2'b10); k++;
        end
        b[k] = 1'b1; k++;
        n = k;
        return b;
    endfunction

    task automatic frame_check(input string req, input bit sel, input logic [8:0] d);
        logic [15:0] got, exp;
        int n;
        exp = expect_frame(d, data9, par_mode, n);
        capture(sel, n, got);
        check(got == exp, req, int'(got), int'(exp));
    endtask

    task automatic t_reset();
        check(txd === 1'b1, "R10 txd idle", int'(txd), 1);
        check(loop_rx === 1'b1, "R10 loop_rx idle", int'(loop_rx), 1);
        check(tx_irq === 1'b1, "R10 irq", int'(tx_irq), 1);
        check(busy === 1'b0, "R10 busy", int'(busy), 0);
    endtask

    task automatic t_basic();
        push(9'h0A5); frame_check("R2 8N1 0xA5", 1'b0, 9'h0A5); wait_idle();
        push(9'h03C); frame_check("R2 8N1 0x3C", 1'b0, 9'h03C); wait_idle();
    endtask

    task automatic t_nine();
        data9 = 1'b1; par_mode = 2'b01;
        push(9'h1A5); frame_check("R3 nine bits no parity", 1'b0, 9'h1A5); wait_idle();
        push(9'h0FF); frame_check("R3 nine bits bit8 zero", 1'b0, 9'h0FF); wait_idle();
        data9 = 1'b0; par_mode = 2'b00;
    endtask

    task automatic t_parity();
        par_mode = 2'b01;
        push(9'h007); frame_check("R4 even parity", 1'b0, 9'h007); wait_idle();
        par_mode = 2'b10;
        push(9'h007); frame_check("R4 odd parity", 1'b0, 9'h007); wait_idle();
        push(9'h003); frame_check("R4 odd parity two ones", 1'b0, 9'h003); wait_idle();
        par_mode = 2'b11;
        push(9'h007); frame_check("R4 mode 11 no parity", 1'b0, 9'h007); wait_idle();
        par_mode = 2'b00;
    endtask

    task automatic t_stop();
        int lo, hi;
        two_stop = 1'b0;
        push(9'h000); push(9'h000);
        run_len(1'b0, lo); run_len(1'b1, hi);
        check(lo == 288, "R5 start+data low", lo, 288);
        check(hi >= 32 && hi <= 34, "R5 one stop", hi, 33);
        wait_idle();
        two_stop = 1'b1;
        push(9'h000); push(9'h000);
        run_len(1'b0, lo); run_len(1'b1, hi);
        check(hi >= 64 && hi <= 66, "R5 two stops", hi, 65);
        wait_idle();
        two_stop = 1'b0;
    endtask

    task automatic t_flow();
        int lows = 0;
        flow_en = 1'b1; cts_n = 1'b1;
        push(9'h055);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, "R6 held by cts", lows, 0);
        check(busy === 1'b0, "R6 not busy while held", int'(busy), 0);
        cts_n = 1'b0;
        frame_check("R6 sends after cts", 1'b0, 9'h055);
        wait_idle();
    endtask

    task automatic t_fifo();
        int lows = 0;
        cts_n = 1'b1;
        push(9'h011); push(9'h022); push(9'h033);
        check(tx_irq === 1'b1, "R1 room after 3", int'(tx_irq), 1);
        push(9'h044);
        check(tx_irq === 1'b0, "R1 full after 4", int'(tx_irq), 0);
        push(9'h055);
        check(tx_irq === 1'b0, "R1 still full", int'(tx_irq), 0);
        cts_n = 1'b0;
        frame_check("R1 order 1", 1'b0, 9'h011);
        frame_check("R1 order 2", 1'b0, 9'h022);
        frame_check("R1 order 3", 1'b0, 9'h033);
        frame_check("R1 order 4", 1'b0, 9'h044);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, "R1 fifth write dropped", lows, 0);
        check(tx_irq === 1'b1, "R1 room when empty", int'(tx_irq), 1);
        flow_en = 1'b0;
        wait_idle();
    endtask

    task automatic t_baud();
        int lo;
        divisor = 16'd3;
        push(9'h0FF);
        run_len(1'b0, lo);
        check(lo == 64, "R7 bit length div3", lo, 64);
        wait_idle();
        divisor = 16'd1;
        push(9'h0FF);
        run_len(1'b0, lo);
        check(lo == 32, "R7 bit length div1", lo, 32);
        wait_idle();
    endtask

    task automatic t_break();
        int lo, hi, lo2;
        @(negedge clk);
        break_req = 1'b1; wr_en = 1'b1; wr_data = 9'h000;
        @(negedge clk);
        break_req = 1'b0; wr_en = 1'b0;
        run_len(1'b0, lo);
        check(lo == 416, "R8 break length", lo, 416);
        run_len(1'b1, hi);
        check(hi >= 32 && hi <= 34, "R8 stop after break", hi, 33);
        run_len(1'b0, lo2);
        check(lo2 == 288, "R8 queued data after break", lo2, 288);
        wait_idle();
    endtask

    task automatic t_loop();
        loopback = 1'b1;
        txd_low_in_loop = 0;
        push(9'h096);
        frame_check("R9 loop_rx carries frame", 1'b1, 9'h096);
        wait_idle();
        check(txd_low_in_loop == 0, "R9 txd idle in loopback", txd_low_in_loop, 0);
        loopback = 1'b0;
        @(negedge clk);
        check(loop_rx === 1'b1, "R9 loop_rx idle when off", int'(loop_rx), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nine();
        t_parity();
        t_stop();
        t_flow();
        t_fifo();
        t_baud();
        t_break();
        t_loop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule